// File: doc/BRIEF.md
# Serial Receive Channel with Flow Control

This block is the receive half of one asynchronous serial channel. It samples the incoming line on a 16x oversampling strobe supplied by an external rate generator. It finds the start of each frame and assembles characters of 5 to 8 data bits, least significant bit first. An optional parity bit and a single stop bit follow the data bits. Each finished character is stored with its parity-error and framing-error flags in a small first-in first-out holding queue. A host reads the queue one entry at a time.

The block drives an active-low ready-to-receive output from the queue fill level, so a remote sender can pause before characters are lost. If a character still completes while the queue is full, it is discarded and a sticky overrun flag is raised. In automatic echo mode each received character is also offered to the local transmit side over a valid/ready handshake.

Top module: `serial_rx_fc`

## Requirements
- R1: After reset, rx_ready, rx_full, overrun and echo_valid are 0 and rts_n is 0.
- R2: A start bit is accepted when the line goes from high to low and is still low at the 8th oversampling strobe. Data bits are then sampled every 16 strobes, least significant bit first. The number of data bits is 5 + cfg_len (cfg_len 0..3 gives 5..8 bits). In the stored character, bits at and above the data length read as 0.
- R3: With cfg_par_en=1 one parity bit follows the data. cfg_par_odd=0 selects even parity, meaning data plus parity holds an even number of ones; cfg_par_odd=1 selects odd parity. A mismatch stores rd_perr=1 with the character. With cfg_par_en=0, rd_perr is 0.
- R4: A stop bit sampled low stores rd_ferr=1 with the character. The receiver then does not start a new frame until the line has been seen high.
- R5: A low pulse shorter than 8 strobes is a false start: no character is stored.
- R6: The queue holds 4 characters and returns them in arrival order on rd_data/rd_perr/rd_ferr. A cycle with rd_en=1 removes the head. rd_en while the queue is empty has no effect.
- R7: rx_ready is 1 while at least one character is held. rx_full is 1 while 4 are held.
- R8: rts_n is 1 while the queue holds 4 characters and returns to 0 in the cycle after a read leaves room.
- R9: A character that completes while 4 are held, with no read in that cycle, is discarded and sets overrun. The stored characters are unchanged. overrun stays 1 until a cycle with ovr_clr=1.
- R10: With cfg_echo=1 every completed character is presented on echo_data with echo_valid=1. It is held stable until a cycle with echo_ready=1. With cfg_echo=0, echo_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rxd | input | 1 | Serial line in, idle high |
| cfg_len | input | 2 | Data length code, bits = 5 + cfg_len |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_echo | input | 1 | Automatic echo enable |
| rd_en | input | 1 | Pop the head character |
| ovr_clr | input | 1 | Clear the overrun flag |
| echo_ready | input | 1 | Transmit side accepts the echo character |
| rd_data | output | 8 | Head character |
| rd_perr | output | 1 | Parity error of head character |
| rd_ferr | output | 1 | Framing error of head character |
| rx_ready | output | 1 | At least one character held |
| rx_full | output | 1 | Queue holds 4 characters |
| overrun | output | 1 | Sticky: a character was lost |
| rts_n | output | 1 | Low while another character can be accepted |
| echo_valid | output | 1 | Echo character pending |
| echo_data | output | 8 | Echo character |

## Verification
The assertions assume that the configuration inputs stay constant while a frame is in flight, and that os_tick is a one-cycle strobe no more often than every other clock. They also assume that the transmit side holds echo_ready as a plain acceptance flag. The bench sets the configuration only between frames, and it pulses the strobe every fourth clock. It changes rxd just after a strobe and holds each bit for 16 strobes, so every sample falls near a bit centre despite the two-stage input synchronizer. Reads, overrun clears and echo acceptances are driven on falling clock edges, and each one lasts a single cycle.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef struct packed {
      logic [7:0] data;
      logic       perr;
      logic       ferr;
   } rx_char_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   function automatic logic [3:0] len_bits(input logic [1:0] code);
      return 4'd5 + {2'b00, code};
   endfunction

endpackage

// File: rtl/rx_frame.sv
module rx_frame
   import uart_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       os_tick,
   input  logic       rxd,
   input  logic [1:0] cfg_len,
   input  logic       cfg_par_en,
   input  logic       cfg_par_odd,
   output logic       done,
   output rx_char_t   char_out
);
   localparam int CW  = $clog2(OVS);
   localparam int MID = OVS / 2;

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("rx_frame: OVS must be even and at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rx_frame: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;
   logic                   line_q;
   rx_state_e              state;
   logic [CW-1:0]          cnt;
   logic [2:0]             bit_idx;
   logic [7:0]             shreg;
   logic                   pbit;
   logic [3:0]             nbits;
   logic [7:0]             aligned;
   logic                   last_tick;

   assign rx_s      = sync_q[SYNC_STAGES-1];
   assign nbits     = len_bits(cfg_len);
   assign aligned   = shreg >> (4'd8 - nbits);
   assign last_tick = (cnt == CW'(OVS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         bit_idx  <= '0;
         shreg    <= '0;
         pbit     <= 1'b0;
         line_q   <= 1'b1;
         done     <= 1'b0;
         char_out <= '0;
      end else begin
         done <= 1'b0;
         if (os_tick) begin
            line_q <= rx_s;
            unique case (state)
               ST_IDLE: begin
                  if (line_q && !rx_s) begin
                     state <= ST_START;
                     cnt   <= CW'(1);
                  end
               end
               ST_START: begin
                  if (cnt == CW'(MID - 1)) begin
                     cnt     <= '0;
                     bit_idx <= '0;
                     state   <= rx_s ? ST_IDLE : ST_DATA;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               ST_DATA: begin
                  cnt <= cnt + CW'(1);
                  if (last_tick) begin
                     cnt   <= '0;
                     shreg <= {rx_s, shreg[7:1]};
                     if ({1'b0, bit_idx} == nbits - 4'd1)
                        state <= cfg_par_en ? ST_PAR : ST_STOP;
                     else
                        bit_idx <= bit_idx + 3'd1;
                  end
               end
               ST_PAR: begin
                  cnt <= cnt + CW'(1);
                  if (last_tick) begin
                     cnt   <= '0;
                     pbit  <= rx_s;
                     state <= ST_STOP;
                  end
               end
               ST_STOP: begin
                  cnt <= cnt + CW'(1);
                  if (last_tick) begin
                     cnt           <= '0;
                     state         <= ST_IDLE;
                     done          <= 1'b1;
                     char_out.data <= aligned;
                     char_out.perr <= cfg_par_en && ((^aligned ^ pbit) != cfg_par_odd);
                     char_out.ferr <= !rx_s;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cfg_len == 2'd0) |-> (char_out.data[7:5] == 3'b000)); // R2
   AST_NO_PERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cfg_par_en) |-> !char_out.perr); // R3
   AST_REARM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && os_tick && !line_q) |=> (state == ST_IDLE)); // R4

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
   import uart_rx_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  rx_char_t                   wdata,
   input  logic                       pop,
   input  logic                       ovr_clr,
   output rx_char_t                   head,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full,
   output logic                       overrun
);
   localparam int AW   = $clog2(DEPTH);
   localparam int CNTW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rx_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   rx_char_t      mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          pop_ok, accept;

   assign full   = (count == CNTW'(DEPTH));
   assign pop_ok = pop && (count != '0);
   assign accept = push && (!full || pop_ok);
   assign head   = mem[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         count   <= '0;
         overrun <= 1'b0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (accept) begin
            mem[wptr] <= wdata;
            wptr      <= wptr + AW'(1);
         end
         if (pop_ok) rptr <= rptr + AW'(1);
         case ({accept, pop_ok})
            2'b10:   count <= count + CNTW'(1);
            2'b01:   count <= count - CNTW'(1);
            default: count <= count;
         endcase
         if (push && !accept) overrun <= 1'b1;
         else if (ovr_clr)    overrun <= 1'b0;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNTW'(DEPTH)); // R6
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && count == '0 && !push) |=> (count == '0)); // R6
   AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (overrun && $stable(count) && $stable(wptr))); // R9
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !ovr_clr) |=> overrun); // R9

endmodule

// File: rtl/rx_echo.sv
module rx_echo
   import uart_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode,
   input  logic       load,
   input  logic [7:0] load_data,
   input  logic       tx_ready,
   output logic       tx_valid,
   output logic [7:0] tx_data
);
   logic take;
   assign take = load && mode && (!tx_valid || tx_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else if (take) begin
         tx_valid <= 1'b1;
         tx_data  <= load_data;
      end else if (tx_ready) begin
         tx_valid <= 1'b0;
      end
   end

   AST_ECHO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R10
   AST_ECHO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode && !tx_valid) |=> !tx_valid); // R10

endmodule

// File: rtl/serial_rx_fc.sv
module serial_rx_fc
   import uart_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DEPTH       = 4,
   parameter bit ECHO_EN     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       os_tick,
   input  logic       rxd,
   input  logic [1:0] cfg_len,
   input  logic       cfg_par_en,
   input  logic       cfg_par_odd,
   input  logic       cfg_echo,
   input  logic       rd_en,
   input  logic       ovr_clr,
   input  logic       echo_ready,
   output logic [7:0] rd_data,
   output logic       rd_perr,
   output logic       rd_ferr,
   output logic       rx_ready,
   output logic       rx_full,
   output logic       overrun,
   output logic       rts_n,
   output logic       echo_valid,
   output logic [7:0] echo_data
);
   localparam int CNTW = $clog2(DEPTH + 1);

   logic            frm_done;
   rx_char_t        frm_char;
   rx_char_t        head;
   logic [CNTW-1:0] fill;
   logic            q_full;

   rx_frame #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) frame_i (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .done(frm_done), .char_out(frm_char)
   );

   rx_fifo #(.DEPTH(DEPTH)) fifo_i (
      .clk(clk), .rst_n(rst_n), .push(frm_done), .wdata(frm_char),
      .pop(rd_en), .ovr_clr(ovr_clr), .head(head), .count(fill),
      .full(q_full), .overrun(overrun)
   );

   generate
      if (ECHO_EN) begin : g_echo
         rx_echo echo_i (
            .clk(clk), .rst_n(rst_n), .mode(cfg_echo), .load(frm_done),
            .load_data(frm_char.data), .tx_ready(echo_ready),
            .tx_valid(echo_valid), .tx_data(echo_data)
         );
      end else begin : g_no_echo
         assign echo_valid = 1'b0;
         assign echo_data  = '0;
      end
   endgenerate

   assign rd_data  = head.data;
   assign rd_perr  = head.perr;
   assign rd_ferr  = head.ferr;
   assign rx_ready = (fill != '0);
   assign rx_full  = q_full;
   assign rts_n    = q_full;

   AST_RTS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ready |-> !rts_n); // R8
   AST_FULL_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> rx_ready); // R7

endmodule

// File: tb/serial_rx_fc_tb_top.sv
module serial_rx_fc_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       cfg_echo = 1'b0;
   logic       rd_en = 1'b0;
   logic       ovr_clr = 1'b0;
   logic       echo_ready = 1'b0;
   logic [7:0] rd_data, echo_data;
   logic       rd_perr, rd_ferr, rx_ready, rx_full, overrun, rts_n, echo_valid;

   int tests = 0;
   int fails = 0;
   logic [1:0] tdiv = 2'd0;

   always #5 clk = ~clk;

   always @(posedge clk) begin
      tdiv    <= tdiv + 2'd1;
      os_tick <= (tdiv == 2'd3);
   end

   serial_rx_fc dut_i (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_echo(cfg_echo), .rd_en(rd_en), .ovr_clr(ovr_clr),
      .echo_ready(echo_ready), .rd_data(rd_data), .rd_perr(rd_perr),
      .rd_ferr(rd_ferr), .rx_ready(rx_ready), .rx_full(rx_full),
      .overrun(overrun), .rts_n(rts_n), .echo_valid(echo_valid),
      .echo_data(echo_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         while (!os_tick) @(posedge clk);
      end
      #1;
   endtask

   task automatic drive_bit(input logic v);
      rxd = v;
      wait_ticks(16);
   endtask

   task automatic send_frame(input logic [7:0] d, input int n, input logic pen,
                             input logic podd, input logic flip, input logic stopv);
      logic [7:0] m;
      m = d & 8'((1 << n) - 1);
      wait_ticks(1);
      drive_bit(1'b0);
      for (int i = 0; i < n; i++) drive_bit(d[i]);
      if (pen) drive_bit(^m ^ podd ^ flip);
      drive_bit(stopv);
   endtask

   task automatic pop();
      @(negedge clk) rd_en = 1'b1;
      @(negedge clk) rd_en = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 rx_ready", rx_ready, 0);
      chk("R1 rx_full", rx_full, 0);
      chk("R1 overrun", overrun, 0);
      chk("R1 rts_n", rts_n, 0);
      chk("R1 echo_valid", echo_valid, 0);
   endtask

   task automatic t_basic();
      cfg_len = 2'd3; cfg_par_en = 1'b0;
      send_frame(8'hA5, 8, 0, 0, 0, 1);
      @(negedge clk);
      chk("R7 ready one", rx_ready, 1);
      chk("R2 data 8bit", rd_data, 8'hA5);
      chk("R3 no parity perr", rd_perr, 0);
      chk("R4 good stop ferr", rd_ferr, 0);
      pop();
      chk("R7 ready empty", rx_ready, 0);
      cfg_len = 2'd0;
      send_frame(8'hFF, 5, 0, 0, 0, 1);
      @(negedge clk);
      chk("R2 5bit upper zero", rd_data, 8'h1F);
      pop();
      cfg_len = 2'd2;
      send_frame(8'h6B, 7, 0, 0, 0, 1);
      @(negedge clk);
      chk("R2 7bit", rd_data, 8'h6B);
      pop();
      cfg_len = 2'd3;
   endtask

   task automatic t_parity();
      cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
      send_frame(8'h35, 8, 1, 0, 0, 1);
      @(negedge clk);
      chk("R3 even good", rd_perr, 0);
      chk("R3 even data", rd_data, 8'h35);
      pop();
      send_frame(8'h35, 8, 1, 0, 1, 1);
      @(negedge clk);
      chk("R3 even bad", rd_perr, 1);
      pop();
      cfg_par_odd = 1'b1;
      send_frame(8'h07, 8, 1, 1, 0, 1);
      @(negedge clk);
      chk("R3 odd good", rd_perr, 0);
      pop();
      cfg_len = 2'd1;
      send_frame(8'h21, 6, 1, 1, 1, 1);
      @(negedge clk);
      chk("R3 odd bad 6bit", rd_perr, 1);
      chk("R2 6bit data", rd_data, 8'h21);
      pop();
      cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
   endtask

   task automatic t_framing();
      send_frame(8'hC3, 8, 0, 0, 0, 0);
      wait_ticks(40);
      @(negedge clk);
      chk("R4 ferr set", rd_ferr, 1);
      chk("R4 ferr data", rd_data, 8'hC3);
      pop();
      chk("R4 no restart while low", rx_ready, 0);
      rxd = 1'b1;
      wait_ticks(20);
      send_frame(8'h3C, 8, 0, 0, 0, 1);
      @(negedge clk);
      chk("R4 next frame", rd_data, 8'h3C);
      chk("R4 next ferr", rd_ferr, 0);
      pop();
      chk("R4 single entry", rx_ready, 0);
   endtask

   task automatic t_false_start();
      wait_ticks(1);
      rxd = 1'b0;
      wait_ticks(4);
      rxd = 1'b1;
      wait_ticks(200);
      @(negedge clk);
      chk("R5 false start", rx_ready, 0);
   endtask

   task automatic t_fifo();
      logic [7:0] v [4];
      v[0] = 8'h11; v[1] = 8'h22; v[2] = 8'h33; v[3] = 8'h44;
      for (int i = 0; i < 4; i++) begin
         send_frame(v[i], 8, 0, 0, 0, 1);
         @(negedge clk);
         if (i < 3) chk("R8 rts low with room", rts_n, 0);
      end
      chk("R7 full", rx_full, 1);
      chk("R8 rts high full", rts_n, 1);
      chk("R9 no overrun yet", overrun, 0);
      send_frame(8'h55, 8, 0, 0, 0, 1);
      @(negedge clk);
      chk("R9 overrun set", overrun, 1);
      chk("R9 head intact", rd_data, 8'h11);
      for (int i = 0; i < 4; i++) begin
         chk("R6 order", rd_data, v[i]);
         pop();
         if (i == 0) begin
            chk("R8 rts low after read", rts_n, 0);
            chk("R7 not full", rx_full, 0);
         end
      end
      chk("R9 dropped char absent", rx_ready, 0);
      chk("R9 overrun sticky", overrun, 1);
      pop();
      chk("R6 empty pop ready", rx_ready, 0);
      send_frame(8'h9E, 8, 0, 0, 0, 1);
      @(negedge clk);
      chk("R6 after empty pop", rd_data, 8'h9E);
      pop();
      chk("R6 drained", rx_ready, 0);
      @(negedge clk) ovr_clr = 1'b1;
      @(negedge clk) ovr_clr = 1'b0;
      chk("R9 overrun cleared", overrun, 0);
   endtask

   task automatic t_echo();
      cfg_echo = 1'b1; echo_ready = 1'b0;
      send_frame(8'h5A, 8, 0, 0, 0, 1);
      @(negedge clk);
      chk("R10 echo valid", echo_valid, 1);
      chk("R10 echo data", echo_data, 8'h5A);
      repeat (10) @(negedge clk);
      chk("R10 echo held", {echo_valid, echo_data}, {1'b1, 8'h5A});
      echo_ready = 1'b1;
      @(negedge clk) echo_ready = 1'b0;
      chk("R10 echo taken", echo_valid, 0);
      chk("R10 stored too", rd_data, 8'h5A);
      pop();
      cfg_echo = 1'b0;
      send_frame(8'h11, 8, 0, 0, 0, 1);
      @(negedge clk);
      chk("R10 echo off", echo_valid, 0);
      pop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_parity();
      t_framing();
      t_false_start();
      t_fifo();
      t_echo();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule